// File: doc/BRIEF.md
# Bank Auto-Precharge Timing Tracker

This block follows the command stream to a single bank of a DDR2-style memory and keeps that bank's row state. A Read or Write command issued with the auto-precharge flag set does not close the row at once. The tracker works out the exact clock edge on which the internal precharge begins and reports that edge as a one-cycle pulse. It then holds off the next Activate until both the precharge interval and the row cycle interval have passed.

For a read, the start edge is the latest of three limits. The first is the end of the burst as offset by the additive latency. The second is the read-to-precharge delay. The third is the minimum row-active time counted from the Activate. For a write, the start waits until the last burst data has been written back, plus the write recovery time. The precharge interval always counts from the edge on which the precharge actually began.

The block can sit in a memory controller as a per-bank legality checker. It can also sit in a behavioural memory model. Commands that break the rules raise a one-cycle flag and are otherwise ignored. All timing values are programmable in clock cycles.

Top module: `bank_ap_tracker`

## Requirements
- R1: An Activate accepted while act_ok is high sets bank_open high in the cycle after the command edge.
- R2: A Read or Write to an open bank with no precharge pending schedules an auto-precharge when ap_flag is 1. When ap_flag is 0 it changes no state and raises no flag.
- R3: For a Read with auto-precharge on edge t, the internal precharge starts on edge t + max(AL + BL/2, AL + tRTP), unless R4 delays it further. BL is 8 when cfg_bl8 is 1 and 4 when it is 0.
- R4: The start edge is never earlier than tRAS edges after the Activate. pre_start is high for exactly the one cycle after the start edge, and bank_open is low from that same cycle.
- R5: For a Write with auto-precharge on edge t, the internal precharge starts on edge t + (AL + CL − 1) + BL/2 + tWR, unless R4 delays it further.
- R6: A Precharge to an open bank with no precharge pending closes the bank on its edge, provided at least tRAS edges have passed since the Activate. pre_start does not pulse for it. A Precharge before tRAS is illegal. A Precharge to a closed bank has no effect and raises no flag.
- R7: act_ok is high exactly when three conditions hold: the bank is closed, at least tRP edges have passed since the edge on which the precharge began, and at least tRC edges have passed since the last accepted Activate.
- R8: An Activate while act_ok is low is illegal. An illegal command raises illegal_cmd for the one cycle after its edge and changes no state.
- R9: A Read or Write to a closed bank, and a Read, Write or Precharge while an auto-precharge is pending, are illegal.
- R10: A command edge carrying more than one of the four command strobes is illegal.
- R11: After a synchronous reset the bank is closed, act_ok is high, and pre_start and illegal_cmd are low. Every timing counter stops at zero. A timing value of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_act | input | 1 | Activate strobe |
| cmd_rd | input | 1 | Read strobe |
| cmd_wr | input | 1 | Write strobe |
| cmd_pre | input | 1 | Explicit Precharge strobe |
| ap_flag | input | 1 | Auto-precharge request with Read or Write |
| cfg_al | input | 6 | Additive latency, cycles |
| cfg_cl | input | 6 | Read latency, cycles |
| cfg_bl8 | input | 1 | 1 selects burst of 8, 0 burst of 4 |
| cfg_tras | input | 6 | Minimum row-active time, cycles |
| cfg_trtp | input | 6 | Read-to-precharge delay, cycles |
| cfg_twr | input | 6 | Write recovery, cycles |
| cfg_trp | input | 6 | Precharge interval, cycles |
| cfg_trc | input | 6 | Activate-to-Activate interval, cycles |
| bank_open | output | 1 | Row open in the bank |
| pre_start | output | 1 | Pulse after the internal precharge start edge |
| act_ok | output | 1 | A new Activate would be accepted |
| illegal_cmd | output | 1 | Pulse after a rejected command |

## Verification
Some properties are checked on every cycle. act_ok is never high while the row is open. pre_start is always a single pulse that leaves the bank closed. An accepted Activate always opens the bank. A rejected command never moves the bank state. Counters held at zero stay there. The exact start edge under each limit can only be shown by the bench scenarios, as can the hold-off measured from the true start edge and the write-recovery sum. Those scenarios compare a timestamp model against the outputs on every cycle.

// File: rtl/bank_ap_pkg.sv
package bank_ap_pkg;

    parameter int CFG_W = 6;
    parameter int CNT_W = CFG_W + 2;
    parameter int N_TMR = 4;

    typedef logic [CFG_W-1:0] cfg_t;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ACT,
        OP_RDAP,
        OP_WRAP,
        OP_PRE,
        OP_BAD
    } op_e;

    typedef struct packed {
        cfg_t al;
        cfg_t cl;
        cfg_t tras;
        cfg_t trtp;
        cfg_t twr;
        cfg_t trp;
        cfg_t trc;
        logic bl8;
    } timing_s;

    // A span of n edges is held as n-1 so that zero means "due on the next edge"
    function automatic cnt_t span_to_load(cnt_t n);
        return (n == '0) ? '0 : n - cnt_t'(1);
    endfunction

    function automatic cnt_t half_burst(timing_s t);
        return t.bl8 ? cnt_t'(4) : cnt_t'(2);
    endfunction

    function automatic cnt_t read_span(timing_s t);
        cnt_t burst_end;
        cnt_t rtp_end;
        burst_end = cnt_t'(t.al) + half_burst(t);
        rtp_end   = cnt_t'(t.al) + cnt_t'(t.trtp);
        return (burst_end > rtp_end) ? burst_end : rtp_end;
    endfunction

    function automatic cnt_t write_span(timing_s t);
        return cnt_t'(t.al) + cnt_t'(t.cl) + half_burst(t) + cnt_t'(t.twr) - cnt_t'(1);
    endfunction

endpackage

// File: rtl/bank_ap_timer.sv
module bank_ap_timer
    import bank_ap_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  cnt_t span,
    output logic zero
);
    cnt_t remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= span_to_load(span);
        end else if (remain != '0) begin
            remain <= remain - cnt_t'(1);
        end
    end

    assign zero = (remain == '0);

    // R11: an idle counter at zero stays at zero
    a_r11_sat_hold: assert property (@(posedge clk) disable iff (rst)
        (!load && zero) |=> zero);

endmodule

// File: rtl/bank_ap_decode.sv
module bank_ap_decode
    import bank_ap_pkg::*;
(
    input  logic cmd_act,
    input  logic cmd_rd,
    input  logic cmd_wr,
    input  logic cmd_pre,
    input  logic ap_flag,
    input  logic open_q,
    input  logic pend_q,
    input  logic act_ok,
    input  logic tras_met,
    output op_e  op
);
    logic [2:0] n_cmd;

    always_comb begin
        n_cmd = 3'(cmd_act) + 3'(cmd_rd) + 3'(cmd_wr) + 3'(cmd_pre);
        op = OP_NONE;
        if (n_cmd > 3'd1) begin
            op = OP_BAD;
        end else if (cmd_act) begin
            op = act_ok ? OP_ACT : OP_BAD;
        end else if (cmd_rd || cmd_wr) begin
            if (!open_q || pend_q)
                op = OP_BAD;
            else if (ap_flag)
                op = cmd_rd ? OP_RDAP : OP_WRAP;
        end else if (cmd_pre) begin
            if (pend_q)
                op = OP_BAD;
            else if (open_q)
                op = tras_met ? OP_PRE : OP_BAD;
        end
    end

endmodule

// File: rtl/bank_ap_tracker.sv
module bank_ap_tracker
    import bank_ap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_act,
    input  logic             cmd_rd,
    input  logic             cmd_wr,
    input  logic             cmd_pre,
    input  logic             ap_flag,
    input  logic [CFG_W-1:0] cfg_al,
    input  logic [CFG_W-1:0] cfg_cl,
    input  logic             cfg_bl8,
    input  logic [CFG_W-1:0] cfg_tras,
    input  logic [CFG_W-1:0] cfg_trtp,
    input  logic [CFG_W-1:0] cfg_twr,
    input  logic [CFG_W-1:0] cfg_trp,
    input  logic [CFG_W-1:0] cfg_trc,
    output logic             bank_open,
    output logic             pre_start,
    output logic             act_ok,
    output logic             illegal_cmd
);
    localparam int T_RAS = 0;
    localparam int T_RC  = 1;
    localparam int T_RP  = 2;
    localparam int T_AP  = 3;

    timing_s          tm;
    op_e              op;
    logic             pend_q;
    logic             fire;
    logic [N_TMR-1:0] t_load;
    logic [N_TMR-1:0] t_zero;
    cnt_t             t_span [N_TMR];

    assign tm = '{al: cfg_al, cl: cfg_cl, tras: cfg_tras, trtp: cfg_trtp,
                  twr: cfg_twr, trp: cfg_trp, trc: cfg_trc, bl8: cfg_bl8};

    assign act_ok = !bank_open && t_zero[T_RP] && t_zero[T_RC];
    assign fire   = pend_q && t_zero[T_AP] && t_zero[T_RAS];

    bank_ap_decode u_dec (
        .cmd_act  (cmd_act),
        .cmd_rd   (cmd_rd),
        .cmd_wr   (cmd_wr),
        .cmd_pre  (cmd_pre),
        .ap_flag  (ap_flag),
        .open_q   (bank_open),
        .pend_q   (pend_q),
        .act_ok   (act_ok),
        .tras_met (t_zero[T_RAS]),
        .op       (op)
    );

    always_comb begin
        t_load[T_RAS] = (op == OP_ACT);
        t_load[T_RC]  = (op == OP_ACT);
        t_load[T_RP]  = fire || (op == OP_PRE);
        t_load[T_AP]  = (op == OP_RDAP) || (op == OP_WRAP);
        t_span[T_RAS] = cnt_t'(tm.tras);
        t_span[T_RC]  = cnt_t'(tm.trc);
        t_span[T_RP]  = cnt_t'(tm.trp);
        t_span[T_AP]  = (op == OP_RDAP) ? read_span(tm) : write_span(tm);
    end

    for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
        bank_ap_timer u_tmr (
            .clk  (clk),
            .rst  (rst),
            .load (t_load[i]),
            .span (t_span[i]),
            .zero (t_zero[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_open   <= 1'b0;
            pend_q      <= 1'b0;
            pre_start   <= 1'b0;
            illegal_cmd <= 1'b0;
        end else begin
            pre_start   <= fire;
            illegal_cmd <= (op == OP_BAD);
            case (op)
                OP_ACT:           bank_open <= 1'b1;
                OP_RDAP, OP_WRAP: pend_q    <= 1'b1;
                OP_PRE:           bank_open <= 1'b0;
                default:          ;
            endcase
            if (fire) begin
                bank_open <= 1'b0;
                pend_q    <= 1'b0;
            end
        end
    end

    // R1: an accepted Activate opens the bank
    a_r1_act_opens: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ACT) |=> bank_open);

    // R7: Activate is never allowed on an open or pending bank
    a_r7_ok_closed: assert property (@(posedge clk) disable iff (rst)
        act_ok |-> (!bank_open && !pend_q));

    // R4: the start pulse leaves the bank closed and lasts one cycle
    a_r4_pulse_closes: assert property (@(posedge clk) disable iff (rst)
        pre_start |-> !bank_open);
    a_r4_pulse_single: assert property (@(posedge clk) disable iff (rst)
        pre_start |=> !pre_start);

    // R8: a rejected command leaves the bank state alone
    a_r8_illegal_hold: assert property (@(posedge clk) disable iff (rst)
        (illegal_cmd && !pre_start) |-> $stable(bank_open));

    // R10: several strobes at once are rejected
    a_r10_multi: assert property (@(posedge clk) disable iff (rst)
        ((cmd_act && cmd_rd) || (cmd_pre && cmd_wr)) |=> illegal_cmd);

endmodule

// File: tb/tb_bank_ap_tracker.sv
module tb_bank_ap_tracker;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_act = 0, cmd_rd = 0, cmd_wr = 0, cmd_pre = 0, ap_flag = 0;
    logic [5:0] cfg_al = 0, cfg_cl = 3, cfg_tras = 6, cfg_trtp = 2;
    logic [5:0] cfg_twr = 3, cfg_trp = 3, cfg_trc = 9;
    logic       cfg_bl8 = 0;
    logic       bank_open, pre_start, act_ok, illegal_cmd;

    int    checks = 0;
    int    errors = 0;
    string tag = "R11";

    // reference model state: absolute edge indices
    int e = 0;
    bit m_open = 0, m_pend = 0, m_pre = 0, m_ill = 0;
    int m_due = 0, m_tras = 0, m_trc = 0, m_trp = 0;

    always #10 clk = ~clk;

    bank_ap_tracker dut (
        .clk(clk), .rst(rst), .cmd_act(cmd_act), .cmd_rd(cmd_rd),
        .cmd_wr(cmd_wr), .cmd_pre(cmd_pre), .ap_flag(ap_flag),
        .cfg_al(cfg_al), .cfg_cl(cfg_cl), .cfg_bl8(cfg_bl8),
        .cfg_tras(cfg_tras), .cfg_trtp(cfg_trtp), .cfg_twr(cfg_twr),
        .cfg_trp(cfg_trp), .cfg_trc(cfg_trc),
        .bank_open(bank_open), .pre_start(pre_start),
        .act_ok(act_ok), .illegal_cmd(illegal_cmd)
    );

    function automatic int at_least1(int v);
        return (v < 1) ? 1 : v;
    endfunction

    task automatic chk(input logic got, input bit exp, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s at edge %0d: got %b expected %b", tag, what, e, got, exp);
        end
    endtask

    task automatic compare_all();
        bit exp_ok;
        exp_ok = !m_open && e >= m_trp && e >= m_trc;
        chk(bank_open, m_open, "bank_open");
        chk(pre_start, m_pre, "pre_start");
        chk(act_ok, exp_ok, "act_ok");
        chk(illegal_cmd, m_ill, "illegal_cmd");
    endtask

    task automatic tick(input bit a, input bit r, input bit w, input bit p, input bit f);
        int  n;
        int  half;
        int  span;
        bit  ill;
        bit  fire;
        cmd_act = a; cmd_rd = r; cmd_wr = w; cmd_pre = p; ap_flag = f;
        half = cfg_bl8 ? 4 : 2;
        fire = m_pend && e >= m_due && e >= m_tras;
        n = int'(a) + int'(r) + int'(w) + int'(p);
        ill = 0;
        if (n > 1) begin
            ill = 1;
        end else if (a) begin
            if (m_open || e < m_trp || e < m_trc) ill = 1;
            else begin
                m_open = 1;
                m_tras = e + at_least1(int'(cfg_tras));
                m_trc  = e + at_least1(int'(cfg_trc));
            end
        end else if (r || w) begin
            if (!m_open || m_pend) ill = 1;
            else if (f) begin
                if (r) begin
                    span = int'(cfg_al) + half;
                    if (int'(cfg_al) + int'(cfg_trtp) > span) span = int'(cfg_al) + int'(cfg_trtp);
                end else begin
                    span = int'(cfg_al) + int'(cfg_cl) - 1 + half + int'(cfg_twr);
                end
                m_pend = 1;
                m_due  = e + span;
            end
        end else if (p) begin
            if (m_pend) ill = 1;
            else if (m_open) begin
                if (e < m_tras) ill = 1;
                else begin
                    m_open = 0;
                    m_trp  = e + at_least1(int'(cfg_trp));
                end
            end
        end
        if (fire) begin
            m_open = 0;
            m_pend = 0;
            m_trp  = e + at_least1(int'(cfg_trp));
        end
        m_pre = fire;
        m_ill = ill;
        e++;
        @(posedge clk);
        @(negedge clk);
        cmd_act = 0; cmd_rd = 0; cmd_wr = 0; cmd_pre = 0; ap_flag = 0;
        compare_all();
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) tick(0, 0, 0, 0, 0);
    endtask

    task automatic settle();
        for (int i = 0; i < 60; i++) if (!m_open || m_pend) tick(0, 0, 0, 0, 0);
        for (int i = 0; i < 60; i++) if (!act_ok) tick(0, 0, 0, 0, 0);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R11: reset state
        tag = "R11";
        compare_all();
        idle(2);

        // R1: open the bank
        tag = "R1";
        tick(1, 0, 0, 0, 0);
        idle(1);

        // R4: nominal edge a+4 comes before tRAS a+6, so start waits
        tag = "R4";
        tick(0, 1, 0, 0, 1);
        idle(6);

        // R7/R8: hammer Activate until it is accepted (tRC 9 from a, tRP 3 from start)
        tag = "R7";
        for (int i = 0; i < 8; i++) tick(1, 0, 0, 0, 0);
        tag = "R8";
        settle();

        // R3: tRTP dominates, AL of 1
        tag = "R3";
        cfg_al = 1; cfg_trtp = 5; cfg_trp = 4; cfg_trc = 8;
        tick(1, 0, 0, 0, 0);
        idle(8);
        tick(0, 1, 0, 0, 1);
        idle(3);
        // R9: commands while pending
        tag = "R9";
        tick(0, 1, 0, 0, 0);
        tick(0, 0, 1, 0, 1);
        tick(0, 0, 0, 1, 0);
        tag = "R3";
        settle();

        // R3: burst of eight dominates
        cfg_bl8 = 1; cfg_trtp = 1;
        tick(1, 0, 0, 0, 0);
        idle(7);
        tick(0, 1, 0, 0, 1);
        settle();

        // R5: write with auto-precharge
        tag = "R5";
        cfg_bl8 = 0; cfg_al = 0; cfg_cl = 4; cfg_twr = 2;
        tick(1, 0, 0, 0, 0);
        tick(0, 0, 1, 0, 1);
        idle(12);
        settle();

        // R2: plain accesses change nothing
        tag = "R2";
        tick(1, 0, 0, 0, 0);
        tick(0, 1, 0, 0, 0);
        tick(0, 0, 1, 0, 0);
        idle(2);

        // R6: early precharge rejected, later accepted, then on closed bank
        tag = "R6";
        tick(0, 0, 0, 1, 0);
        idle(3);
        tick(0, 0, 0, 1, 0);
        tick(0, 0, 0, 1, 0);
        idle(5);

        // R9: access to a closed bank
        tag = "R9";
        tick(0, 1, 0, 0, 1);
        tick(0, 0, 1, 0, 0);
        settle();

        // R10: two strobes at once
        tag = "R10";
        tick(1, 1, 0, 0, 0);
        tick(0, 0, 1, 1, 0);
        tick(1, 0, 0, 0, 0);
        tick(0, 1, 1, 0, 1);
        idle(6);
        tick(0, 0, 0, 1, 0);
        settle();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule